// File: doc/BRIEF.md
# SMBus Alert Responder

This block is the alert side of an I2C target. A pulse on the interrupt-request input latches a pending alert. The block then pulls the shared, active-low alert line low. The host answers by reading from the alert response address (7-bit value 0001100 with the read bit set).

When the alert is pending and enabled, the block acknowledges that read. It then returns its own 7-bit address on SDA, most significant bit first, with a 0 as the eighth bit. While it sends, it compares each 1 it releases against the wire. If another target pulls the line low, the block has lost. It stops driving and keeps its alert asserted, so the host must run another round.

When the block wins, the host's acknowledge clock after the address byte releases the alert. If the host keeps acknowledging, the block pads the transfer with all-ones bytes until it sees a NACK. SCL and SDA arrive already synchronised and filtered. The alert and SDA outputs are pull-down enables for open-drain pins.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset both pull-down outputs (`sdaPullDn`, `alertDriveLow`) are 0, so SDA and the alert line are released.
- R2: A one-cycle pulse on `irqIn` asserts `alertDriveLow` (1 = line pulled low) from the following cycle when `alertEn` is 1. With `alertEn` at 0 the pulse has no effect and the alert stays released.
- R3: A read to the alert response address (byte 0x19 = 0001100 followed by R/W = 1) is acknowledged when the alert is asserted. The block pulls SDA low during the ninth SCL high phase.
- R4: No acknowledge is given when the alert is not asserted, when the byte is 0x18 (write bit), or when the address is any other value.
- R5: After acknowledging, the block returns the byte {ownAddr, 0}, most significant bit first. Each bit is placed on SDA while SCL is low.
- R6: If SDA reads 0 at an SCL rising edge while the block is sending a 1, the block releases SDA for the rest of the transfer and keeps the alert asserted.
- R7: On a won transfer, `alertDriveLow` stays 1 through the eighth address bit. It goes to 0 at the rising SCL edge of the ninth clock (the host's acknowledge bit).
- R8: While the host acknowledges each returned byte, the block sends 0xFF bytes. A NACK ends its transmission.
- R9: `sdaPullDn` changes only while SCL is low. SDA is sampled on SCL rising edges.
- R10: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Clocked bits before any START are ignored. A STOP or repeated START returns the block to address reception and leaves the alert state unchanged.
- R11: An `irqIn` pulse arriving between START and STOP of a won transfer does not keep the alert asserted through the release. It asserts the alert again once the STOP is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronised SCL level |
| sdaIn | input | 1 | Synchronised SDA level (the wired-AND bus value) |
| ownAddr | input | 7 | The target's own 7-bit address |
| alertEn | input | 1 | Enables the alert function |
| irqIn | input | 1 | Interrupt request; a pulse sets the pending alert |
| sdaPullDn | output | 1 | 1 = pull SDA low |
| alertDriveLow | output | 1 | 1 = pull the alert line low (alert asserted) |

## Verification
The hardest state to reach from the ports is the lost-arbitration case. The block must release SDA after its first 1 meets a 0, yet keep the alert low. The bench reaches it by adding a rival target to its wired-AND bus model. The rival drives its own address bits during the read, so the first bit disagrees. A second, unopposed transfer then shows that the same pending alert still wins and releases. Late requests are reached by pulsing the interrupt between the acknowledged address and the host's NACK.

// File: rtl/smba_pkg.sv
package smba_pkg;

  localparam logic [6:0] ALERT_RESP_ADDR = 7'b0001100;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACKWAIT,
    ST_ACK,
    ST_TX,
    ST_TXEND,
    ST_MACK,
    ST_MNEXT,
    ST_WAIT
  } smbaState_e;

  // control -> datapath
  typedef struct packed {
    logic rxShift;
    logic cntClr;
    logic cntInc;
    logic txLoadAddr;
    logic txLoadOnes;
    logic txShift;
    logic sdaAck;
    logic sdaRelease;
    logic alertClear;
    logic busy;
  } smbaStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic araMatch;
    logic lastBit;
    logic txBit;
    logic sdaNow;
    logic alertOn;
  } smbaStatus_t;

endpackage

// File: rtl/smba_datapath.sv
module smba_datapath
  import smba_pkg::*;
#(
  parameter int AddrW = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [AddrW-1:0] ownAddr,
  input  logic             alertEn,
  input  logic             irqIn,
  input  smbaStrobe_t      strb,
  output smbaStatus_t      stat,
  output logic             sdaPullDn,
  output logic             alertDriveLow
);

  localparam int ByteW = AddrW + 1;
  localparam int CntW  = $clog2(ByteW);
  localparam logic [ByteW-1:0] AraRead = ByteW'({ALERT_RESP_ADDR, 1'b1});

  logic             sclQ, sdaQ;
  logic [ByteW-2:0] rxReg;
  logic [ByteW-1:0] txReg;
  logic [CntW-1:0]  bitCnt;
  logic             sdaDrv;
  logic             pendQ;
  logic             reqSeenQ;
  logic [ByteW-1:0] rxByte;

  // line history for edge and bus-condition detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  assign rxByte = {rxReg, sdaIn};

  always_comb begin
    stat.sclRise  = sclIn & ~sclQ;
    stat.sclFall  = ~sclIn & sclQ;
    stat.startDet = sclIn & sclQ & sdaQ & ~sdaIn;
    stat.stopDet  = sclIn & sclQ & ~sdaQ & sdaIn;
    stat.araMatch = (rxByte == AraRead);
    stat.lastBit  = (bitCnt == CntW'(ByteW - 1));
    stat.txBit    = txReg[ByteW-1];
    stat.sdaNow   = sdaIn;
    stat.alertOn  = pendQ;
  end

  // receive shifter and bit counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg  <= '0;
      bitCnt <= '0;
    end else begin
      if (strb.rxShift) rxReg <= rxByte[ByteW-2:0];
      if (strb.cntClr)      bitCnt <= '0;
      else if (strb.cntInc) bitCnt <= bitCnt + CntW'(1);
    end
  end

  // transmit shifter and SDA pull-down
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg  <= '1;
      sdaDrv <= 1'b0;
    end else begin
      if (strb.txLoadAddr)      txReg <= {ownAddr, 1'b0};
      else if (strb.txLoadOnes) txReg <= '1;
      else if (strb.txShift)    txReg <= {txReg[ByteW-2:0], 1'b1};

      if (strb.sdaRelease)      sdaDrv <= 1'b0;
      else if (strb.sdaAck)     sdaDrv <= 1'b1;
      else if (strb.txLoadAddr) sdaDrv <= ~ownAddr[AddrW-1];
      else if (strb.txLoadOnes) sdaDrv <= 1'b0;
      else if (strb.txShift)    sdaDrv <= ~txReg[ByteW-2];
    end
  end

  // pending alert; requests seen mid-transfer are held until the bus frees
  always_ff @(posedge clk) begin
    if (!rstN || !alertEn) begin
      pendQ    <= 1'b0;
      reqSeenQ <= 1'b0;
    end else begin
      if (strb.alertClear)
        pendQ <= 1'b0;
      else if (!strb.busy && (irqIn || reqSeenQ))
        pendQ <= 1'b1;

      if (!strb.busy)  reqSeenQ <= 1'b0;
      else if (irqIn)  reqSeenQ <= 1'b1;
    end
  end

  assign sdaPullDn     = sdaDrv;
  assign alertDriveLow = pendQ;

  assert_sda_scl_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrv) |-> !$past(sclIn));

  assert_alert_release_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendQ) |-> ($past(strb.alertClear) || !$past(alertEn)));

  assert_no_alert_when_disabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(alertEn) |-> !pendQ);

endmodule

// File: rtl/smba_ctrl.sv
module smba_ctrl
  import smba_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  smbaStatus_t stat,
  output smbaStrobe_t strb
);

  smbaState_e stateQ, stateD;
  logic       firstQ, firstD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      firstQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      firstQ <= firstD;
    end
  end

  always_comb begin
    strb      = '0;
    stateD    = stateQ;
    firstD    = firstQ;
    strb.busy = (stateQ != ST_IDLE);

    if (stat.stopDet) begin
      stateD          = ST_IDLE;
      strb.sdaRelease = 1'b1;
    end else if (stat.startDet) begin
      stateD          = ST_ADDR;
      strb.cntClr     = 1'b1;
      strb.sdaRelease = 1'b1;
    end else begin
      unique case (stateQ)
        ST_IDLE: ;
        ST_ADDR: begin
          if (stat.sclRise) begin
            strb.rxShift = 1'b1;
            strb.cntInc  = 1'b1;
            if (stat.lastBit)
              stateD = (stat.araMatch && stat.alertOn) ? ST_ACKWAIT : ST_WAIT;
          end
        end
        ST_ACKWAIT: begin
          if (!stat.alertOn) stateD = ST_WAIT;
          else if (stat.sclFall) begin
            strb.sdaAck = 1'b1;
            stateD      = ST_ACK;
          end
        end
        ST_ACK: begin
          if (stat.sclFall) begin
            strb.txLoadAddr = 1'b1;
            strb.cntClr     = 1'b1;
            firstD          = 1'b1;
            stateD          = ST_TX;
          end
        end
        ST_TX: begin
          if (stat.sclRise) begin
            if (stat.txBit && !stat.sdaNow) begin
              strb.sdaRelease = 1'b1;
              stateD          = ST_WAIT;
            end else if (stat.lastBit) begin
              stateD = ST_TXEND;
            end else begin
              strb.cntInc = 1'b1;
            end
          end else if (stat.sclFall) begin
            strb.txShift = 1'b1;
          end
        end
        ST_TXEND: begin
          if (stat.sclFall) begin
            strb.sdaRelease = 1'b1;
            stateD          = ST_MACK;
          end
        end
        ST_MACK: begin
          if (stat.sclRise) begin
            strb.alertClear = firstQ;
            firstD          = 1'b0;
            stateD          = stat.sdaNow ? ST_WAIT : ST_MNEXT;
          end
        end
        ST_MNEXT: begin
          if (stat.sclFall) begin
            strb.txLoadOnes = 1'b1;
            strb.cntClr     = 1'b1;
            stateD          = ST_TX;
          end
        end
        ST_WAIT: ;
        default: stateD = ST_IDLE;
      endcase
    end
  end

  assert_ack_needs_alert_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.sdaAck |-> stat.alertOn);

  assert_stop_to_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    stat.stopDet |=> (stateQ == ST_IDLE));

  assert_loss_leaves_tx_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_TX && stat.sclRise && stat.txBit && !stat.sdaNow) |=> (stateQ == ST_WAIT));

  assert_clear_only_after_tx_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.alertClear |-> (stateQ == ST_MACK));

endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder
  import smba_pkg::*;
#(
  parameter int AddrW = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [AddrW-1:0] ownAddr,
  input  logic             alertEn,
  input  logic             irqIn,
  output logic             sdaPullDn,
  output logic             alertDriveLow
);

  smbaStrobe_t strb;
  smbaStatus_t stat;

  smba_ctrl ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .stat (stat),
    .strb (strb)
  );

  smba_datapath #(.AddrW(AddrW)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .sclIn         (sclIn),
    .sdaIn         (sdaIn),
    .ownAddr       (ownAddr),
    .alertEn       (alertEn),
    .irqIn         (irqIn),
    .strb          (strb),
    .stat          (stat),
    .sdaPullDn     (sdaPullDn),
    .alertDriveLow (alertDriveLow)
  );

endmodule

// File: tb/smb_alert_responder_tb_top.sv
module smb_alert_responder_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scl = 1'b1;
  logic       sdaM = 1'b1;
  logic [6:0] ownAddr = 7'h5A;
  logic       alertEn = 1'b1;
  logic       irq = 1'b0;
  logic       sdaPullDn, alertDriveLow;
  logic       sdaLine;
  int         nChk = 0;
  int         nFail = 0;
  logic       r9Bad = 1'b0;
  logic       drvPrev = 1'b0;
  logic       sclPrev = 1'b1;

  always #5 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullDn;

  smb_alert_responder dut_i (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .ownAddr(ownAddr), .alertEn(alertEn), .irqIn(irq),
    .sdaPullDn(sdaPullDn), .alertDriveLow(alertDriveLow)
  );

  // R9 monitor: a change of the pull-down must follow an edge where SCL was low
  always @(posedge clk) begin
    if (rstN && (sdaPullDn !== drvPrev) && sclPrev) r9Bad <= 1'b1;
    drvPrev <= sdaPullDn;
    sclPrev <= scl;
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitCycle(input logic drv, output logic seen);
    waitN(2); sdaM = drv;
    waitN(4); scl = 1'b1;
    waitN(4); seen = sdaLine;
    waitN(4); scl = 1'b0;
  endtask

  task automatic busStart;
    sdaM = 1'b1; waitN(4);
    scl = 1'b1;  waitN(4);
    sdaM = 1'b0; waitN(4);
    scl = 1'b0;
  endtask

  task automatic busStop;
    waitN(2); sdaM = 1'b0; waitN(4);
    scl = 1'b1;  waitN(4);
    sdaM = 1'b1; waitN(4);
  endtask

  task automatic wrByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bitCycle(b[i], s);
    bitCycle(1'b1, s);
    acked = ~s;
  endtask

  task automatic rdByte(input logic [7:0] rival, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(rival[i], s);
      d[i] = s;
    end
  endtask

  task automatic hostAck(input logic ack);
    logic s;
    bitCycle(~ack, s);
  endtask

  task automatic pulseIrq;
    irq = 1'b1; waitN(1);
    irq = 1'b0; waitN(1);
  endtask

  task automatic t_reset;
    chk("R1", "alert after reset", {7'b0, alertDriveLow}, 8'd0);
    chk("R1", "sda after reset", {7'b0, sdaPullDn}, 8'd0);
  endtask

  task automatic t_noPendingNoAck;
    logic a;
    busStart; wrByte(8'h19, a); busStop;
    chk("R4", "ack without alert", {7'b0, a}, 8'd0);
  endtask

  task automatic t_enableGate;
    alertEn = 1'b0; waitN(1);
    pulseIrq;
    chk("R2", "alert while disabled", {7'b0, alertDriveLow}, 8'd0);
    alertEn = 1'b1; waitN(1);
    pulseIrq;
    chk("R2", "alert after irq", {7'b0, alertDriveLow}, 8'd1);
  endtask

  task automatic t_noStart;
    logic a;
    scl = 1'b0;
    wrByte(8'h19, a);
    waitN(2); scl = 1'b1; waitN(4);
    chk("R10", "ack without START", {7'b0, a}, 8'd0);
    chk("R10", "alert kept", {7'b0, alertDriveLow}, 8'd1);
  endtask

  task automatic t_writeThenLose;
    logic a;
    logic [7:0] d;
    busStart; wrByte(8'h18, a);
    chk("R4", "ack on write bit", {7'b0, a}, 8'd0);
    busStart; wrByte(8'h19, a);
    chk("R3", "ack after repeated START", {7'b0, a}, 8'd1);
    chk("R10", "alert across repeated START", {7'b0, alertDriveLow}, 8'd1);
    rdByte(8'h40, d);
    chk("R6", "bus byte with rival", d, 8'h40);
    chk("R6", "sda released after loss", {7'b0, sdaPullDn}, 8'd0);
    hostAck(1'b0);
    busStop;
    chk("R6", "alert kept after loss", {7'b0, alertDriveLow}, 8'd1);
  endtask

  task automatic t_otherAddr;
    logic a;
    busStart; wrByte(8'h41, a); busStop;
    chk("R4", "ack on other address", {7'b0, a}, 8'd0);
  endtask

  task automatic t_win;
    logic a;
    logic [7:0] d;
    busStart; wrByte(8'h19, a);
    chk("R3", "ack with alert", {7'b0, a}, 8'd1);
    rdByte(8'hFF, d);
    chk("R5", "returned address", d, {ownAddr, 1'b0});
    chk("R7", "alert before ninth clock", {7'b0, alertDriveLow}, 8'd1);
    hostAck(1'b1);
    chk("R7", "alert after ninth clock", {7'b0, alertDriveLow}, 8'd0);
    rdByte(8'hFF, d);
    chk("R8", "first pad byte", d, 8'hFF);
    hostAck(1'b1);
    rdByte(8'hFF, d);
    chk("R8", "second pad byte", d, 8'hFF);
    hostAck(1'b0);
    busStop;
    chk("R8", "sda released after NACK", {7'b0, sdaPullDn}, 8'd0);
    busStart; wrByte(8'h19, a); busStop;
    chk("R4", "ack after alert cleared", {7'b0, a}, 8'd0);
  endtask

  task automatic t_lateIrq;
    logic a;
    logic [7:0] d;
    pulseIrq;
    busStart; wrByte(8'h19, a);
    pulseIrq;
    rdByte(8'hFF, d);
    hostAck(1'b0);
    chk("R11", "released despite late irq", {7'b0, alertDriveLow}, 8'd0);
    busStop;
    waitN(2);
    chk("R11", "re-asserted after STOP", {7'b0, alertDriveLow}, 8'd1);
  endtask

  initial begin
    waitN(5);
    rstN = 1'b1;
    waitN(2);
    t_reset;
    t_noPendingNoAck;
    t_enableGate;
    t_noStart;
    t_writeThenLose;
    t_otherAddr;
    t_win;
    t_lateIrq;
    chk("R9", "sda changed while SCL high", {7'b0, r9Bad}, 8'd0);
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule